// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words that joins two unrelated clock domains. A producer pushes words on its own clock through a pair of write enables. A consumer pulls them on a second clock through a pair of read enables. Read data lands in an output register, and an output-enable input either passes that register to the data output or forces the output to zero. The two clocks may also be one shared clock.

Five level flags report how full the buffer is. Empty and almost-empty are produced on the read clock. Full, half-full and almost-full are produced on the write clock. The two almost thresholds are offsets held in a small program register, and both reset to 127 words. The level of the second write enable while reset is held picks the mode for the whole session. If it is held low, the block enters offset-load mode. In that mode, a write-clock edge that sees the second write enable low and the first write enable low stores the data input into the offset register instead of pushing a word. Read and write pointers cross between the domains as Gray code through two-flop synchronizers.

Top module: `dcfifo_flags`

## Requirements
- R1: On a rising write-clock edge with `wr_en_n` = 0, `wr_en_ld` = 1 and full = 0, `din` is stored. Words come out of the read port in the order they were stored.
- R2: On a rising read-clock edge with `rd_en_n_a` = 0, `rd_en_n_b` = 0 and empty = 0, the oldest word is loaded into the output register at that edge. With either read enable high, the output register holds its value and no word is consumed.
- R3: A write attempt while full is dropped. The count stays at DEPTH and the stored words are unchanged.
- R4: A read attempt while empty is dropped. The output register keeps its value and empty stays 1.
- R5: While `rst_n` is 0 on the clock edges, both pointers clear, the output register clears to 0, and both offsets return to 127. After reset, empty = 1, almost_empty = 1, full = 0, half_full = 0 and almost_full = 0.
- R6: empty = 1 exactly when the stored count is 0. full = 1 exactly when the stored count is DEPTH.
- R7: half_full = 1 exactly when the stored count is greater than DEPTH/2.
- R8: almost_empty = 1 exactly when the count is at most the almost-empty offset. almost_full = 1 exactly when the count is at least DEPTH minus the almost-full offset. Both offsets default to 127.
- R9: When `wr_en_ld` = 0 during reset, offset-load mode is entered. Each write-clock edge with `wr_en_n` = 0 and `wr_en_ld` = 0 then stores `din[AW-1:0]` into an offset. The loads go to the almost-empty offset first, then the almost-full offset, and keep alternating. A load stores no FIFO word. Data writes (`wr_en_ld` = 1) work as in R1.
- R10: With `out_en` = 0, `dout` is 0. Restoring `out_en` = 1 shows the unchanged output register.
- R11: In normal mode, `wr_en_n` = 0 with `wr_en_ld` = 0 stores nothing. `wr_en_ld` = 1 with `wr_en_n` = 1 also stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, synchronous in each domain |
| wr_en_n | input | 1 | First write enable, active low |
| wr_en_ld | input | 1 | Second write enable (active high) and offset-load strobe |
| din | input | DW | Write data, or offset value in load mode |
| rd_en_n_a | input | 1 | First read enable, active low |
| rd_en_n_b | input | 1 | Second read enable, active low |
| out_en | input | 1 | Output enable; 0 forces dout to zero |
| dout | output | DW | Gated output register |
| empty | output | 1 | No words stored (read domain) |
| almost_empty | output | 1 | Count at or below almost-empty offset (read domain) |
| full | output | 1 | DEPTH words stored (write domain) |
| half_full | output | 1 | Count above DEPTH/2 (write domain) |
| almost_full | output | 1 | Count at or above DEPTH minus almost-full offset (write domain) |

## Verification
Results in the same domain as the stimulus are due at the next edge of that clock. The read register changes at the read edge that consumes the word and is sampled 1 ns after that edge. A flag owned by the other domain is due within three edges of the other clock, counting the pointer register and the two synchronizer stages. After every burst, the bench idles for four edges of each clock before it compares any flag with the count kept by its model. Reads are only issued after such an idle period, so a word that is still crossing the domains is never expected.

// File: rtl/dcf_pkg.sv
// Package dcf_pkg
// Shared definitions for the dual-clock FIFO: the offset-load slot
// selector and the reset value of both almost offsets.
package dcf_pkg;
    // Which offset the next load in offset-load mode writes.
    typedef enum logic {
        SLOT_AE = 1'b0,
        SLOT_AF = 1'b1
    } ofs_slot_e;

    // Offset loaded into both thresholds by reset.
    localparam int DEFAULT_OFS = 127;
endpackage

// File: rtl/dcf_sync.sv
// Module dcf_sync
// Two-flop synchronizer for a vector. It assumes the vector is either
// Gray coded (one bit changes per update) or quasi-static while it is
// sampled. Synchronous active-low reset loads RST_VAL.
module dcf_sync #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Purpose: two register stages toward the destination clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/dcf_mem.sv
// Module dcf_mem
// Storage array written on the write clock, plus the output register
// loaded on the read clock. Array cells have no reset. The output
// register resets to zero and changes only on a granted read.
module dcf_mem #(
    parameter int DW = 9,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Purpose: store one word per granted write.
    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Purpose: load the oldest word into the output register per granted read.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= cells[raddr];
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
// Module dcf_wr_ctrl
// Write-domain control: write pointer (binary and Gray), mode capture
// during reset, offset program register, and the full, half-full and
// almost-full flags. The read pointer arrives already synchronized, in
// Gray code. DEPTH = 2**AW with AW >= 2 is assumed.
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          wr_en_ld,
    input  logic [AW-1:0] ofs_in,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          wr_fire,
    output logic          full,
    output logic          half_full,
    output logic          almost_full,
    output logic          load_mode,
    output logic [AW-1:0] ae_ofs
);
    localparam logic [AW:0]   FULL_CNT = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0]   HALF_CNT = {2'b01, {(AW-1){1'b0}}};
    localparam logic [AW-1:0] DEF_OFS  = AW'(DEFAULT_OFS);

    logic [AW:0]   wbin_q, wgray_q, wbin_nx;
    logic [AW:0]   rbin_s, wcount;
    logic [AW-1:0] ae_ofs_q, af_ofs_q;
    logic          load_mode_q;
    ofs_slot_e     slot_q;
    logic          wr_req, ld_req;

    function automatic logic [AW:0] gray_to_bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Purpose: decode the paired write enables into data and load requests.
    always_comb begin
        wr_req  = !wr_en_n && wr_en_ld;
        ld_req  = load_mode_q && !wr_en_n && !wr_en_ld;
        wbin_nx = wbin_q + 1'b1;
    end

    // Purpose: full when the write pointer leads the read pointer by DEPTH.
    always_comb begin
        full    = (wgray_q == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        wr_fire = wr_req && !full;
    end

    // Purpose: advance the write pointer on each granted write.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (wr_fire) begin
            wbin_q  <= wbin_nx;
            wgray_q <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Purpose: sample the mode while reset is held; keep it afterwards.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            load_mode_q <= !wr_en_ld;
        end
    end

    // Purpose: offset program register with alternating load slot.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            ae_ofs_q <= DEF_OFS;
            af_ofs_q <= DEF_OFS;
            slot_q   <= SLOT_AE;
        end else if (ld_req) begin
            if (slot_q == SLOT_AE) begin
                ae_ofs_q <= ofs_in;
                slot_q   <= SLOT_AF;
            end else begin
                af_ofs_q <= ofs_in;
                slot_q   <= SLOT_AE;
            end
        end
    end

    // Purpose: level flags from the write-side view of the count.
    always_comb begin
        rbin_s      = gray_to_bin(rgray_s);
        wcount      = wbin_q - rbin_s;
        half_full   = (wcount > HALF_CNT);
        almost_full = (wcount >= (FULL_CNT - {1'b0, af_ofs_q}));
    end

    assign wbin      = wbin_q;
    assign wgray     = wgray_q;
    assign load_mode = load_mode_q;
    assign ae_ofs    = ae_ofs_q;
endmodule

// File: rtl/dcf_rd_ctrl.sv
// Module dcf_rd_ctrl
// Read-domain control: read pointer (binary and Gray), and the empty and
// almost-empty flags. The write pointer and the almost-empty offset
// arrive already synchronized; the offset is assumed stable while used.
module dcf_rd_ctrl #(
    parameter int AW = 8
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en_n_a,
    input  logic          rd_en_n_b,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_ofs_s,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          rd_fire,
    output logic          empty,
    output logic          almost_empty
);
    logic [AW:0] rbin_q, rgray_q, rbin_nx;
    logic [AW:0] wbin_s, rcount;
    logic        rd_req;

    function automatic logic [AW:0] gray_to_bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Purpose: grant a read when both enables are active and data exists.
    always_comb begin
        rd_req  = !rd_en_n_a && !rd_en_n_b;
        empty   = (rgray_q == wgray_s);
        rd_fire = rd_req && !empty;
        rbin_nx = rbin_q + 1'b1;
    end

    // Purpose: advance the read pointer on each granted read.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (rd_fire) begin
            rbin_q  <= rbin_nx;
            rgray_q <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Purpose: almost-empty from the read-side view of the count.
    always_comb begin
        wbin_s       = gray_to_bin(wgray_s);
        rcount       = wbin_s - rbin_q;
        almost_empty = (rcount <= {1'b0, ae_ofs_s});
    end

    assign rbin  = rbin_q;
    assign rgray = rgray_q;
endmodule

// File: rtl/dcfifo_flags.sv
// Module dcfifo_flags
// Top of the dual-clock FIFO with programmable level flags. It joins the
// write and read controllers, the storage and the Gray-pointer and offset
// synchronizers. Assumes DEPTH is a power of two, DEPTH >= 4 and
// DW >= log2(DEPTH) so offsets fit in din. Reset must be held for at
// least two edges of each clock.
module dcfifo_flags
    import dcf_pkg::*;
#(
    parameter int DW    = 9,
    parameter int DEPTH = 256
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          wr_en_ld,
    input  logic [DW-1:0] din,
    input  logic          rd_en_n_a,
    input  logic          rd_en_n_b,
    input  logic          out_en,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          almost_empty,
    output logic          full,
    output logic          half_full,
    output logic          almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] DEF_OFS = AW'(DEFAULT_OFS);

    logic [AW:0]   wptr, wgray, rptr, rgray;
    logic [AW:0]   wgray_s, rgray_s;
    logic [AW-1:0] ae_ofs, ae_ofs_s;
    logic          wr_fire, rd_fire, load_mode;
    logic [DW-1:0] rdata_q;

    dcf_wr_ctrl #(.AW(AW)) u_wr (
        .wclk        (wclk),
        .rst_n       (rst_n),
        .wr_en_n     (wr_en_n),
        .wr_en_ld    (wr_en_ld),
        .ofs_in      (din[AW-1:0]),
        .rgray_s     (rgray_s),
        .wbin        (wptr),
        .wgray       (wgray),
        .wr_fire     (wr_fire),
        .full        (full),
        .half_full   (half_full),
        .almost_full (almost_full),
        .load_mode   (load_mode),
        .ae_ofs      (ae_ofs)
    );

    dcf_rd_ctrl #(.AW(AW)) u_rd (
        .rclk         (rclk),
        .rst_n        (rst_n),
        .rd_en_n_a    (rd_en_n_a),
        .rd_en_n_b    (rd_en_n_b),
        .wgray_s      (wgray_s),
        .ae_ofs_s     (ae_ofs_s),
        .rbin         (rptr),
        .rgray        (rgray),
        .rd_fire      (rd_fire),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    dcf_sync #(.W(AW+1), .RST_VAL('0)) u_sync_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    dcf_sync #(.W(AW+1), .RST_VAL('0)) u_sync_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    dcf_sync #(.W(AW), .RST_VAL(DEF_OFS)) u_sync_ofs (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (ae_ofs),
        .q     (ae_ofs_s)
    );

    dcf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk    (wclk),
        .we      (wr_fire),
        .waddr   (wptr[AW-1:0]),
        .wdata   (din),
        .rclk    (rclk),
        .rst_n   (rst_n),
        .re      (rd_fire),
        .raddr   (rptr[AW-1:0]),
        .rdata_q (rdata_q)
    );

    // Purpose: output enable gates the output register onto dout.
    always_comb begin
        dout = out_en ? rdata_q : '0;
    end
endmodule

// File: rtl/dcfifo_flags_chk.sv
// Module dcfifo_flags_chk
// Assertion checker bound to dcfifo_flags. It observes ports and the
// internal pointers; it drives nothing.
module dcfifo_flags_chk #(
    parameter int DW = 9,
    parameter int AW = 8
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_en_n,
    input logic          wr_en_ld,
    input logic          rd_en_n_a,
    input logic          rd_en_n_b,
    input logic          out_en,
    input logic [DW-1:0] dout,
    input logic [DW-1:0] rdata_q,
    input logic          empty,
    input logic          full,
    input logic          half_full,
    input logic          almost_full,
    input logic          load_mode,
    input logic [AW:0]   wptr,
    input logic [AW:0]   rptr
);
    // R2: a granted read advances the read pointer by one
    assert_read_advance_R2: assert property (@(posedge rclk) disable iff (!rst_n)
        (!rd_en_n_a && !rd_en_n_b && !empty) |=> (rptr == $past(rptr) + 1'b1));

    // R3: a write attempt while full leaves the write pointer alone
    assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
        (!wr_en_n && wr_en_ld && full) |=> $stable(wptr));

    // R4: a read attempt while empty changes neither pointer nor register
    assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rst_n)
        (!rd_en_n_a && !rd_en_n_b && empty) |=> ($stable(rptr) && $stable(rdata_q)));

    // R5: empty is reported on the first read edge out of reset
    assert_empty_after_reset_R5: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(rst_n) |-> empty);

    // R7, R8: a full buffer is also above half and almost full
    assert_full_levels_R7: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> (half_full && almost_full));

    // R9: an offset load stores no FIFO word
    assert_load_no_push_R9: assert property (@(posedge wclk) disable iff (!rst_n)
        (load_mode && !wr_en_n && !wr_en_ld) |=> $stable(wptr));

    // R10: output is zero while the output enable is low
    always_comb begin
        if (rst_n && !out_en) begin
            assert_oe_gate_R10: assert (dout == '0);
        end
    end
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DW(DW), .AW(AW)) u_chk (
    .wclk        (wclk),
    .rclk        (rclk),
    .rst_n       (rst_n),
    .wr_en_n     (wr_en_n),
    .wr_en_ld    (wr_en_ld),
    .rd_en_n_a   (rd_en_n_a),
    .rd_en_n_b   (rd_en_n_b),
    .out_en      (out_en),
    .dout        (dout),
    .rdata_q     (rdata_q),
    .empty       (empty),
    .full        (full),
    .half_full   (half_full),
    .almost_full (almost_full),
    .load_mode   (load_mode),
    .wptr        (wptr),
    .rptr        (rptr)
);

// File: tb/tb_dcfifo_flags.sv
// Bench for dcfifo_flags: directed corner cases plus seeded random bursts,
// checked against a queue model and flag functions of the model count.
module tb_dcfifo_flags;
    localparam int DW    = 9;
    localparam int DEPTH = 256;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_n = 1'b1;
    logic          wr_en_ld = 1'b1;
    logic [DW-1:0] din = '0;
    logic          rd_en_n_a = 1'b1;
    logic          rd_en_n_b = 1'b1;
    logic          out_en = 1'b1;
    logic [DW-1:0] dout;
    logic          empty, almost_empty, full, half_full, almost_full;

    int            n_checks = 0;
    int            n_errors = 0;
    bit            done = 1'b0;
    logic [DW-1:0] model_q[$];
    logic [DW-1:0] last_rd = '0;
    int            ae_ofs = 127;
    int            af_ofs = 127;

    dcfifo_flags #(.DW(DW), .DEPTH(DEPTH)) dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_en_n(wr_en_n), .wr_en_ld(wr_en_ld), .din(din),
        .rd_en_n_a(rd_en_n_a), .rd_en_n_b(rd_en_n_b), .out_en(out_en),
        .dout(dout), .empty(empty), .almost_empty(almost_empty),
        .full(full), .half_full(half_full), .almost_full(almost_full)
    );

    always #2 wclk = ~wclk;   // 250 MHz write clock
    always #3 rclk = ~rclk;   // unrelated read clock

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_hf(input int c);
        return (c > DEPTH / 2) ? 1 : 0;
    endfunction
    function automatic int exp_ae(input int c);
        return (c <= ae_ofs) ? 1 : 0;
    endfunction
    function automatic int exp_af(input int c);
        return (c >= DEPTH - af_ofs) ? 1 : 0;
    endfunction

    task automatic settle();
        repeat (4) @(posedge rclk);
        repeat (4) @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic check_flags(input string ctx);
        int c;
        c = model_q.size();
        chk({ctx, " R6 empty"}, int'(empty), (c == 0) ? 1 : 0);
        chk({ctx, " R6 full"}, int'(full), (c == DEPTH) ? 1 : 0);
        chk({ctx, " R7 half_full"}, int'(half_full), exp_hf(c));
        chk({ctx, " R8 almost_empty"}, int'(almost_empty), exp_ae(c));
        chk({ctx, " R8 almost_full"}, int'(almost_full), exp_af(c));
    endtask

    task automatic do_reset(input bit load_sel);
        rst_n     = 1'b0;
        wr_en_n   = 1'b1;
        wr_en_ld  = load_sel ? 1'b0 : 1'b1;
        rd_en_n_a = 1'b1;
        rd_en_n_b = 1'b1;
        repeat (5) @(posedge rclk);
        repeat (5) @(posedge wclk);
        @(negedge wclk);
        rst_n = 1'b1;
        model_q.delete();
        last_rd = '0;
        ae_ofs  = 127;
        af_ofs  = 127;
        settle();
    endtask

    // One write-clock cycle with the data write enables active.
    task automatic write_word(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en_n  = 1'b0;
        wr_en_ld = 1'b1;
        din      = d;
        if (model_q.size() < DEPTH) model_q.push_back(d);
    endtask

    task automatic write_idle();
        @(negedge wclk);
        wr_en_n = 1'b1;
    endtask

    // One read-clock cycle with both read enables active; output checked after the edge.
    task automatic read_word(input string tag);
        @(negedge rclk);
        rd_en_n_a = 1'b0;
        rd_en_n_b = 1'b0;
        @(posedge rclk);
        #1;
        if (model_q.size() > 0) last_rd = model_q.pop_front();
        chk(tag, int'(dout), int'(last_rd));
    endtask

    task automatic read_idle();
        @(negedge rclk);
        rd_en_n_a = 1'b1;
        rd_en_n_b = 1'b1;
    endtask

    task automatic load_ofs(input logic [DW-1:0] v);
        @(negedge wclk);
        wr_en_n  = 1'b0;
        wr_en_ld = 1'b0;
        din      = v;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R5: reset state
        do_reset(1'b0);
        check_flags("reset R5");
        chk("R5 dout after reset", int'(dout), 0);

        // R11: single write enable stores nothing
        @(negedge wclk); wr_en_n = 1'b0; wr_en_ld = 1'b0; din = 9'h055;
        repeat (3) @(negedge wclk);
        wr_en_n = 1'b1; wr_en_ld = 1'b1;
        repeat (3) @(negedge wclk);
        settle();
        chk("R11 no store, empty", int'(empty), 1);

        // R4: reads while empty are dropped
        read_word("R4 read when empty");
        read_word("R4 read when empty again");
        read_idle();
        chk("R4 empty held", int'(empty), 1);

        // R1, R2: a short stream then single-enable read does nothing
        for (int i = 0; i < 5; i++) write_word(9'(9'h100 + i));
        write_idle();
        settle();
        check_flags("five words");
        @(negedge rclk); rd_en_n_a = 1'b0; rd_en_n_b = 1'b1;
        repeat (3) @(negedge rclk);
        rd_en_n_a = 1'b1; rd_en_n_b = 1'b0;
        repeat (3) @(negedge rclk);
        rd_en_n_b = 1'b1;
        #1;
        chk("R2 single read enable holds dout", int'(dout), 0);
        for (int i = 0; i < 5; i++) read_word("R1 R2 order");
        read_idle();

        // R10: output enable gating
        @(negedge rclk); out_en = 1'b0; #1;
        chk("R10 dout zero when disabled", int'(dout), 0);
        @(negedge rclk); out_en = 1'b1; #1;
        chk("R10 dout restored", int'(dout), int'(last_rd));
        settle();
        check_flags("drained");

        // R3, R6: fill to full, then overflow attempts
        for (int i = 0; i < DEPTH; i++) write_word(9'(i * 7 + 3));
        write_idle();
        settle();
        check_flags("full");
        for (int i = 0; i < 3; i++) write_word(9'h1AA);
        write_idle();
        settle();
        check_flags("R3 after overflow");
        for (int i = 0; i < DEPTH; i++) read_word("R3 contents intact");
        read_idle();
        settle();
        check_flags("emptied");
        read_word("R4 read after drain");
        read_idle();

        // Random bursts in normal mode
        for (int it = 0; it < 30; it++) begin
            int n;
            n = int'($urandom_range(1, 60));
            if ($urandom_range(0, 1) == 0) begin
                for (int k = 0; k < n; k++) write_word(9'($urandom));
                write_idle();
            end else begin
                for (int k = 0; k < n; k++) read_word("R1 random order");
                read_idle();
            end
            settle();
            check_flags("random");
        end

        // R9: offset-load mode
        do_reset(1'b1);
        load_ofs(9'd7);
        load_ofs(9'd10);
        load_ofs(9'd5);
        @(negedge wclk); wr_en_n = 1'b1;
        ae_ofs = 5;
        af_ofs = 10;
        settle();
        chk("R9 loads store no word", int'(empty), 1);
        check_flags("R9 loaded");
        for (int i = 0; i < 5; i++) write_word(9'(9'h0F0 + i));
        write_idle();
        settle();
        check_flags("R9 count at ae offset");
        write_word(9'h0AB);
        write_idle();
        settle();
        check_flags("R9 count above ae offset");
        while (model_q.size() < DEPTH - 11) write_word(9'($urandom));
        write_idle();
        settle();
        check_flags("R9 below af threshold");
        write_word(9'h033);
        write_idle();
        settle();
        check_flags("R9 at af threshold");
        read_word("R9 first data word");
        read_idle();
        settle();
        check_flags("R9 after read");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule